// File: doc/BRIEF.md
# Four-Queue Express/Preemptible Transmit Arbiter

This block chooses which of four transmit queues may start the next frame on a shared link. Each queue raises a request line. The block answers with a one-hot grant. The grant is registered and stays on the chosen queue until that queue signals that its frame is complete. The block then drops the grant for one cycle and arbitrates again.

Two controls set the order. A reverse bit swaps the fixed queue order. When it is clear, the lowest-numbered queue is served first. When it is set, the highest-numbered queue is served first. A preemption-enable bit, together with a per-queue preemptible mask, divides the queues into two classes. When preemption is on, an express queue (mask bit clear) always beats a preemptible queue (mask bit set). The queue order then settles ties inside each class. When preemption is off, the mask has no effect and every queue is in one class.

Next to the arbiter, a small encoder turns a requested minimum non-final fragment size, given in bytes, into a 2-bit multiplier m, where the fragment size is 64 x (m + 1). The request is rounded up to the nearest supported size.

Top module: `txq_class_arbiter`

## Requirements
- R1: During reset, and in the first cycle after reset is released, `grant_o` is 4'b0000.
- R2: While no queue requests and no grant is held, `grant_o` stays 4'b0000.
- R3: With preemption disabled and `reverse_i` = 0, the lowest-numbered requesting queue wins. Queue q is granted with bit q of `grant_o` set.
- R4: With `reverse_i` = 1 and preemption disabled, the highest-numbered requesting queue wins.
- R5: With `preempt_en_i` = 0, the value of `preempt_mask_i` has no effect on which queue is granted.
- R6: With `preempt_en_i` = 1, a requesting queue whose mask bit is 0 (express) is granted before any queue whose mask bit is 1 (preemptible). Within a class, the order set by `reverse_i` decides.
- R7: `grant_o` is one-hot or zero. When no grant is held, a grant follows a request on the next rising clock edge, and only a queue that was requesting at that edge is granted.
- R8: A held grant does not change while the granted queue's `done_i` bit is low. During that time, changes to the requests, the mask, the enable and the reverse bit have no effect, and neither do `done_i` bits of other queues.
- R9: A `done_i` pulse from the granted queue clears `grant_o` to zero at the next edge. Arbitration on current inputs runs at the edge after that.
- R10: `frag_mult_o` is the smallest m in 0..3 with 64 x (m + 1) >= `frag_req_i`. It is 0 for a request of 0, and 3 for any request above 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 4 | Per-queue transmit request |
| preempt_mask_i | input | 4 | Per-queue preemptible tag (1 = preemptible) |
| preempt_en_i | input | 1 | Enables express-over-preemptible classing |
| reverse_i | input | 1 | 1 = highest-numbered queue first |
| done_i | input | 4 | Per-queue frame-complete strobe |
| frag_req_i | input | 16 | Requested minimum fragment size in bytes |
| grant_o | output | 4 | One-hot grant, registered |
| frag_mult_o | output | 2 | Fragment size multiplier |

## Verification
A wrong priority key shows up at the ports at once. It grants the wrong queue on the first edge after the requests appear, so it can be seen one cycle after a new pattern is applied. A broken hold register would let the grant move or vanish while a frame is still in progress, and the hold test sees this within one cycle of the disturbing input. A missed release would keep the grant after `done_i`, and the idle-cycle check after each pulse catches it. The fragment encoder is combinational, so a wrong threshold gives a wrong multiplier in the same cycle. The sweep across every byte boundary exposes an off-by-one.

// File: rtl/txarb_pkg.sv
// Package: shared widths and helpers for the transmit arbiter.
// Assumes the queue count is a power of two or at least two.
package txarb_pkg;

    // Width of a queue index for a given queue count.
    function automatic int qidx_w(input int nq);
        return (nq > 1) ? $clog2(nq) : 1;
    endfunction

endpackage

// File: rtl/txarb_rank.sv
// Module: builds a per-queue priority key {class, position}.
// A larger key wins. The class bit is set for express queues
// only while preemption is enabled. The position encodes the fixed order,
// which the reverse bit flips. Assumes the keys are used combinationally.
module txarb_rank #(
    parameter int NUM_Q = 4,
    localparam int QW = txarb_pkg::qidx_w(NUM_Q),
    localparam int KW = QW + 1
) (
    input  logic [NUM_Q-1:0]         preempt_mask_i,
    input  logic                     preempt_en_i,
    input  logic                     reverse_i,
    output logic [NUM_Q-1:0][KW-1:0] key_o
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_Q; gi++) begin : g_key
            logic          hi_class;
            logic [QW-1:0] pos;
            // Express class only exists when preemption is on.
            always_comb hi_class = preempt_en_i & ~preempt_mask_i[gi];
            // Normal order favours low indices; reverse favours high ones.
            always_comb pos = reverse_i ? QW'(gi) : QW'(NUM_Q - 1 - gi);
            always_comb key_o[gi] = {hi_class, pos};
        end
    endgenerate

endmodule

// File: rtl/txarb_pick.sv
// Module: selects the requesting queue with the largest key.
// Keys are unique because positions are unique, so the result is one-hot
// or zero. Uses a full comparison matrix: one compare level plus an AND.
module txarb_pick #(
    parameter int NUM_Q = 4,
    localparam int QW = txarb_pkg::qidx_w(NUM_Q),
    localparam int KW = QW + 1
) (
    input  logic [NUM_Q-1:0]         req_i,
    input  logic [NUM_Q-1:0][KW-1:0] key_i,
    output logic [NUM_Q-1:0]         win_o
);

    genvar gi;
    generate
        for (gi = 0; gi < NUM_Q; gi++) begin : g_win
            logic [NUM_Q-1:0] beaten;
            // A queue is beaten by any other requester holding a larger key.
            always_comb begin
                for (int j = 0; j < NUM_Q; j++) begin
                    beaten[j] = (j != gi) && req_i[j] && (key_i[j] > key_i[gi]);
                end
            end
            // Wins when requesting and nobody beats it.
            always_comb win_o[gi] = req_i[gi] & ~(|beaten);
        end
    endgenerate

endmodule

// File: rtl/txarb_hold.sv
// Module: grant register. Loads the picked queue when idle, holds it
// until the owner strobes done, then spends one idle cycle at zero.
// Assumes the pick input is one-hot or zero.
module txarb_hold #(
    parameter int NUM_Q = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_Q-1:0] pick_i,
    input  logic [NUM_Q-1:0] req_i,
    input  logic [NUM_Q-1:0] done_i,
    output logic [NUM_Q-1:0] grant_o
);

    logic [NUM_Q-1:0] grant_q;
    logic             busy;
    logic             release_now;

    // Busy while any grant is held.
    always_comb busy = |grant_q;
    // Only the owner's done strobe ends the grant.
    always_comb release_now = |(grant_q & done_i);

    // Grant state: load when idle, clear on owner done, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
        end else if (!busy) begin
            grant_q <= pick_i;
        end else if (release_now) begin
            grant_q <= '0;
        end
    end

    always_comb grant_o = grant_q;

    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (grant_q == '0));

    p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_q));

    p_from_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_q == '0) |=> ((grant_q & ~$past(req_i)) == '0));

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_q == '0) && (req_i == '0)) |=> (grant_q == '0));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_q != '0) && ((grant_q & done_i) == '0)) |=> $stable(grant_q));

    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_q & done_i) != '0) |=> (grant_q == '0));

endmodule

// File: rtl/txarb_frag_enc.sv
// Module: encodes a requested fragment size in bytes into a multiplier
// m with size = UNIT * (m + 1), rounding up and saturating at the top
// level. Purely combinational; the clock and reset feed the checks only.
module txarb_frag_enc #(
    parameter int FRAG_W = 16,
    parameter int UNIT   = 64,
    parameter int LEVELS = 4,
    localparam int MW = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAG_W-1:0] frag_req_i,
    output logic [MW-1:0]     frag_mult_o
);

    logic [LEVELS-2:0] over;

    genvar gk;
    generate
        for (gk = 0; gk < LEVELS - 1; gk++) begin : g_thr
            // Set when the request does not fit in level gk.
            always_comb over[gk] = frag_req_i > FRAG_W'(UNIT * (gk + 1));
        end
    endgenerate

    // Thresholds rise, so the count of exceeded levels is the multiplier.
    always_comb begin
        frag_mult_o = '0;
        for (int k = 0; k < LEVELS - 1; k++) begin
            frag_mult_o = frag_mult_o + MW'(over[k]);
        end
    end

    p_frag_fits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(frag_req_i) <= UNIT * LEVELS) |->
        ((int'(frag_mult_o) + 1) * UNIT >= int'(frag_req_i)));

    p_frag_min_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frag_mult_o != '0) |-> (int'(frag_mult_o) * UNIT < int'(frag_req_i)));

endmodule

// File: rtl/txq_class_arbiter.sv
// Module: four-queue transmit arbiter with a reversible fixed order and
// express-over-preemptible classing, plus a fragment-size encoder.
// Assumes the done strobes are one-cycle pulses from the owning queue.
module txq_class_arbiter #(
    parameter int NUM_Q  = 4,
    parameter int FRAG_W = 16,
    parameter int UNIT   = 64,
    parameter int LEVELS = 4,
    localparam int QW = txarb_pkg::qidx_w(NUM_Q),
    localparam int KW = QW + 1,
    localparam int MW = $clog2(LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_Q-1:0]  req_i,
    input  logic [NUM_Q-1:0]  preempt_mask_i,
    input  logic              preempt_en_i,
    input  logic              reverse_i,
    input  logic [NUM_Q-1:0]  done_i,
    input  logic [FRAG_W-1:0] frag_req_i,
    output logic [NUM_Q-1:0]  grant_o,
    output logic [MW-1:0]     frag_mult_o
);

    logic [NUM_Q-1:0][KW-1:0] key;
    logic [NUM_Q-1:0]         pick;

    txarb_rank #(.NUM_Q(NUM_Q)) u_rank (
        .preempt_mask_i (preempt_mask_i),
        .preempt_en_i   (preempt_en_i),
        .reverse_i      (reverse_i),
        .key_o          (key)
    );

    txarb_pick #(.NUM_Q(NUM_Q)) u_pick (
        .req_i (req_i),
        .key_i (key),
        .win_o (pick)
    );

    txarb_hold #(.NUM_Q(NUM_Q)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .pick_i  (pick),
        .req_i   (req_i),
        .done_i  (done_i),
        .grant_o (grant_o)
    );

    txarb_frag_enc #(.FRAG_W(FRAG_W), .UNIT(UNIT), .LEVELS(LEVELS)) u_frag (
        .clk         (clk),
        .rst_n       (rst_n),
        .frag_req_i  (frag_req_i),
        .frag_mult_o (frag_mult_o)
    );

    p_express_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant_o == '0) && preempt_en_i && ((req_i & ~preempt_mask_i) != '0))
        |=> ((grant_o & ~$past(preempt_mask_i)) != '0));

endmodule

// File: tb/txq_class_arbiter_bench.sv
// Bench: exhaustive sweep of request/mask/enable/reverse patterns, a hold
// test, and a byte-by-byte fragment encoder sweep.
module txq_class_arbiter_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  req, mask, done;
    logic        pe, rev;
    logic [15:0] frag;
    logic [3:0]  grant;
    logic [1:0]  mult;
    int          n_checks = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    txq_class_arbiter u_txq_class_arbiter (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req),
        .preempt_mask_i (mask),
        .preempt_en_i   (pe),
        .reverse_i      (rev),
        .done_i         (done),
        .frag_req_i     (frag),
        .grant_o        (grant),
        .frag_mult_o    (mult)
    );

    // Records one check; prints one FAIL line on a mismatch.
    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected winner: express class first when enabled, then order.
    function automatic logic [3:0] exp_grant(input logic [3:0] r, input logic [3:0] m,
                                             input logic p, input logic v);
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 0 && !p) continue;
            for (int s = 0; s < 4; s++) begin
                int q;
                q = v ? 3 - s : s;
                if (r[q] && (pass == 1 || !m[q])) return 4'(1 << q);
            end
        end
        return 4'b0000;
    endfunction

    // Expected multiplier: ceiling of size / 64, minus one, clamped.
    function automatic int exp_mult(input int b);
        int m;
        if (b == 0) return 0;
        m = (b - 1) / 64;
        return (m > 3) ? 3 : m;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req = '0; mask = '0; done = '0; pe = 1'b0; rev = 1'b0; frag = '0;
        req = 4'b1111;
        repeat (3) @(negedge clk);
        chk("R1 grant in reset", grant, 0);
        rst_n = 1'b1;
        req = '0;
        @(negedge clk);
        chk("R1 first cycle after reset", grant, 0);
        repeat (3) @(negedge clk);
        chk("R2 idle grant zero", grant, 0);

        // R3 R4 R5 R6 R7 R9: every request/mask/enable/reverse combination.
        for (int c = 0; c < 1024; c++) begin
            logic [3:0] e;
            req  = 4'(c);
            mask = 4'(c >> 4);
            pe   = c[8];
            rev  = c[9];
            e = exp_grant(req, mask, pe, rev);
            @(negedge clk);
            if (!pe && !rev)     chk("R3 default order", grant, e);
            else if (!pe && rev) chk("R4 reverse order", grant, e);
            else                 chk("R6 express first", grant, e);
            if (!pe) chk("R5 mask ignored", grant, exp_grant(req, 4'b0000, 1'b0, rev));
            chk("R7 onehot", $countones(grant) <= 1, 1);
            done = grant;
            @(negedge clk);
            chk("R9 release to zero", grant, 0);
            done = '0;
            req = '0;
            @(negedge clk);
        end

        // R8: hold against every disturbance, then R9 re-arbitration.
        pe = 1'b0; rev = 1'b0; mask = '0; req = 4'b0101;
        @(negedge clk);
        chk("R8 initial grant", grant, 4'b0001);
        rev = 1'b1; req = 4'b1111; mask = 4'b0001; pe = 1'b1;
        @(negedge clk);
        chk("R8 held across control change", grant, 4'b0001);
        done = 4'b1110;
        @(negedge clk);
        chk("R8 foreign done ignored", grant, 4'b0001);
        req = 4'b0000; done = 4'b0000;
        @(negedge clk);
        chk("R8 held after request drop", grant, 4'b0001);
        req = 4'b1111; pe = 1'b0; done = 4'b0001;
        @(negedge clk);
        chk("R9 cleared on owner done", grant, 0);
        done = 4'b0000;
        @(negedge clk);
        chk("R9 rearbitrates reverse", grant, 4'b1000);
        done = 4'b1000; req = '0;
        @(negedge clk);
        done = '0;
        @(negedge clk);
        chk("R2 idle after release", grant, 0);

        // R10: fragment encoder over every byte count to 320, then large ones.
        for (int b = 0; b <= 320; b++) begin
            frag = 16'(b);
            #1;
            chk($sformatf("R10 frag %0d", b), mult, exp_mult(b));
        end
        frag = 16'd1000;  #1; chk("R10 frag 1000", mult, 3);
        frag = 16'hFFFF;  #1; chk("R10 frag max", mult, 3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule